// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-up to an operational state without software help. After reset is released it raises clock enable, then walks a fixed list of commands on one command port. The list closes precharge on all banks, programs the extended mode register, loads the mode register with a DLL reset, precharges again, issues two auto-refreshes and then loads the mode register a second time with the DLL reset cleared. Between commands it drives NOP for a programmable number of clock cycles.

Once the last wait has elapsed the block raises a done flag. The flag stays high until the next reset. At that point the memory controller proper takes over the command port. Each wait is a parameter in clock cycles, so a fast simulation can shorten every gap while silicon keeps the full values.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While `rst` is high, `cke` is 0 and `done` is 0. The command pins show deselect (`cs_n`,`ras_n`,`cas_n`,`we_n` = 1,1,1,1). `addr` and `ba` are zero.
- R2: The first clock edge with `rst` low sets `cke` to 1 and shows a NOP with `addr` = 0 and `ba` = 0. NOP then continues for `WAIT_CKE` cycles.
- R3: The command pins, in the order `cs_n`,`ras_n`,`cas_n`,`we_n`, carry these codes: NOP = 0,1,1,1; precharge = 0,0,1,0; mode-register load = 0,0,0,0; auto-refresh = 0,0,0,1.
- R4: The commands come in this order. First, precharge with `addr`=0x0400 and `ba`=0. Next, mode-register load with `ba`=1 and `addr`=0x0000. Next, mode-register load with `ba`=0 and `addr`=0x0132. Then precharge (0x0400, bank 0), then two auto-refreshes (`addr`=0, `ba`=0). Last, mode-register load with `ba`=0 and `addr`=0x0032.
- R5: Each command lasts exactly one cycle. NOP with `addr`=0 and `ba`=0 follows it for that step's wait, which may be zero. The wait is `WAIT_PRE` after a precharge, `WAIT_MRD` after the extended load, `WAIT_LOAD` after either mode-register load and `WAIT_REF` after each refresh.
- R6: `done` rises in the cycle right after the final wait ends. It stays high with NOP, `addr`=0 and `ba`=0 until reset.
- R7: Once raised, `cke` stays 1 until reset.
- R8: A reset asserted in the middle of the sequence returns the block to the R1 state. The whole sequence then restarts from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| done | output | 1 | Initialization complete, sticky |

## Verification
The assertions take for granted that `rst` is synchronous and the clock runs freely, since reset is the block's only input. They also assume that a mode-register load only ever carries one of the three programmed bank/address pairs. The stimulus keeps to this by changing `rst` only on the falling clock edge. It runs the bench with short waits, one of them zero, so that back-to-back commands are covered. A reset inserted partway through the list checks that the sequence restarts cleanly.

// File: rtl/ddr_powerup_pkg.sv
package ddr_powerup_pkg;

    typedef enum logic [1:0] {
        PH_PWRUP,
        PH_ISSUE,
        PH_WAIT,
        PH_DONE
    } phase_e;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PREALL,
        CMD_LOADMR,
        CMD_REFRESH
    } cmd_e;

    localparam int NUM_STEPS = 8;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    function automatic int max5(int a, int b, int c, int d, int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/ddr_powerup_step_rom.sv
module ddr_powerup_step_rom
    import ddr_powerup_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int CNT_W     = 8,
    parameter int WAIT_CKE  = 20,
    parameter int WAIT_PRE  = 4,
    parameter int WAIT_MRD  = 2,
    parameter int WAIT_LOAD = 200,
    parameter int WAIT_REF  = 4
) (
    input  logic [STEP_W-1:0] step,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [CNT_W-1:0]  wait_len,
    output logic              is_last
);

    always_comb begin
        cmd      = CMD_NOP;
        addr     = '0;
        ba       = '0;
        wait_len = CNT_W'(WAIT_CKE);
        is_last  = 1'b0;
        unique case (step)
            3'd0: begin
                cmd      = CMD_NOP;
                wait_len = CNT_W'(WAIT_CKE);
            end
            3'd1, 3'd4: begin
                cmd      = CMD_PREALL;
                addr     = ADDR_W'('h400);
                wait_len = CNT_W'(WAIT_PRE);
            end
            3'd2: begin
                cmd      = CMD_LOADMR;
                ba       = BA_W'(1);
                wait_len = CNT_W'(WAIT_MRD);
            end
            3'd3: begin
                cmd      = CMD_LOADMR;
                addr     = ADDR_W'('h132);
                wait_len = CNT_W'(WAIT_LOAD);
            end
            3'd5, 3'd6: begin
                cmd      = CMD_REFRESH;
                wait_len = CNT_W'(WAIT_REF);
            end
            default: begin
                cmd      = CMD_LOADMR;
                addr     = ADDR_W'('h032);
                wait_len = CNT_W'(WAIT_LOAD);
                is_last  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ddr_powerup_pin_enc.sv
module ddr_powerup_pin_enc
    import ddr_powerup_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    always_comb begin
        unique case (cmd)
            CMD_NOP:     {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_PREALL:  {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_LOADMR:  {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            CMD_REFRESH: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default:     {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
    end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
    import ddr_powerup_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2,
    parameter int WAIT_CKE  = 20,
    parameter int WAIT_PRE  = 4,
    parameter int WAIT_MRD  = 2,
    parameter int WAIT_LOAD = 200,
    parameter int WAIT_REF  = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              done
);

    localparam int MAX_WAIT = max5(WAIT_CKE, WAIT_PRE, WAIT_MRD, WAIT_LOAD, WAIT_REF);
    localparam int CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);

    typedef struct packed {
        phase_e              phase;
        logic [STEP_W-1:0]   step;
        logic [CNT_W-1:0]    cnt;
    } seq_state_t;

    seq_state_t state_d, state_q;

    cmd_e              rom_cmd;
    logic [ADDR_W-1:0] rom_addr;
    logic [BA_W-1:0]   rom_ba;
    logic [CNT_W-1:0]  rom_wait;
    logic              rom_last;
    cmd_e              pin_cmd;

    ddr_powerup_step_rom #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
        .WAIT_CKE(WAIT_CKE), .WAIT_PRE(WAIT_PRE), .WAIT_MRD(WAIT_MRD),
        .WAIT_LOAD(WAIT_LOAD), .WAIT_REF(WAIT_REF)
    ) u_rom (
        .step(state_q.step),
        .cmd(rom_cmd),
        .addr(rom_addr),
        .ba(rom_ba),
        .wait_len(rom_wait),
        .is_last(rom_last)
    );

    // Next-state computation
    always_comb begin
        state_d = state_q;
        unique case (state_q.phase)
            PH_PWRUP: begin
                state_d.phase = PH_ISSUE;
                state_d.step  = '0;
                state_d.cnt   = '0;
            end
            PH_ISSUE: begin
                if (rom_wait != '0) begin
                    state_d.phase = PH_WAIT;
                    state_d.cnt   = rom_wait - CNT_W'(1);
                end else if (rom_last) begin
                    state_d.phase = PH_DONE;
                end else begin
                    state_d.step  = state_q.step + STEP_W'(1);
                end
            end
            PH_WAIT: begin
                if (state_q.cnt != '0) begin
                    state_d.cnt = state_q.cnt - CNT_W'(1);
                end else if (rom_last) begin
                    state_d.phase = PH_DONE;
                end else begin
                    state_d.phase = PH_ISSUE;
                    state_d.step  = state_q.step + STEP_W'(1);
                end
            end
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.phase <= PH_PWRUP;
            state_q.step  <= '0;
            state_q.cnt   <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from registered state
    always_comb begin
        pin_cmd = CMD_NOP;
        addr    = '0;
        ba      = '0;
        if (state_q.phase == PH_PWRUP) begin
            pin_cmd = CMD_DESEL;
        end else if (state_q.phase == PH_ISSUE) begin
            pin_cmd = rom_cmd;
            addr    = rom_addr;
            ba      = rom_ba;
        end
    end

    assign cke  = (state_q.phase != PH_PWRUP);
    assign done = (state_q.phase == PH_DONE);

    ddr_powerup_pin_enc u_enc (
        .cmd(pin_cmd),
        .cs_n(cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n(we_n)
    );

    // Assertions
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_cke_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && addr == '0 && ba == '0 && cke));

    assert_no_cmd_before_cke_R1: assert property (@(posedge clk)
        !cke |-> (cs_n && !done));

    assert_loadmr_values_R4: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |->
            ((ba == BA_W'(1) && addr == '0) ||
             (ba == '0 && (addr == ADDR_W'('h132) || addr == ADDR_W'('h032)))));

    assert_prech_a10_R4: assert property (@(posedge clk) disable iff (rst)
        ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> (addr == ADDR_W'('h400) && ba == '0));

endmodule

// File: tb/sim_ddr_powerup_seq.sv
`timescale 1ns/1ps
module sim_ddr_powerup_seq;

    localparam int AW      = 13;
    localparam int BW      = 2;
    localparam int T_CKE   = 3;
    localparam int T_PRE   = 2;
    localparam int T_MRD   = 1;
    localparam int T_LOAD  = 7;
    localparam int T_REF   = 0;

    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_LMR  = 4'b0000;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_DES  = 4'b1111;

    typedef struct {
        logic [20:0] vec;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    ddr_powerup_seq #(
        .ADDR_W(AW), .BA_W(BW),
        .WAIT_CKE(T_CKE), .WAIT_PRE(T_PRE), .WAIT_MRD(T_MRD),
        .WAIT_LOAD(T_LOAD), .WAIT_REF(T_REF)
    ) u0 (
        .clk(clk), .rst(rst), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .done(done)
    );

    function automatic logic [20:0] mk(logic k, logic [3:0] p, logic [12:0] a,
                                       logic [1:0] b, logic d);
        return {k, p, a, b, d};
    endfunction

    function automatic logic [20:0] observed();
        return {cke, cs_n, ras_n, cas_n, we_n, addr, ba, done};
    endfunction

    task automatic check(logic [20:0] exp, string tag);
        checks++;
        if (observed() !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, observed(), exp, $time);
        end
    endtask

    task automatic push_step(logic [3:0] p, logic [12:0] a, logic [1:0] b,
                             int w, string tag);
        exp_t e;
        e.vec = mk(1'b1, p, a, b, 1'b0);
        e.tag = tag;
        exp_q.push_back(e);
        for (int i = 0; i < w; i++) begin
            e.vec = mk(1'b1, P_NOP, 13'h0, 2'd0, 1'b0);
            e.tag = "R5 wait NOP";
            exp_q.push_back(e);
        end
    endtask

    task automatic build_model();
        exp_q.delete();
        push_step(P_NOP, 13'h000, 2'd0, T_CKE,  "R2 cke raise");
        push_step(P_PRE, 13'h400, 2'd0, T_PRE,  "R3 R4 precharge 1");
        push_step(P_LMR, 13'h000, 2'd1, T_MRD,  "R3 R4 ext mode load");
        push_step(P_LMR, 13'h132, 2'd0, T_LOAD, "R3 R4 mode load dll reset");
        push_step(P_PRE, 13'h400, 2'd0, T_PRE,  "R3 R4 precharge 2");
        push_step(P_REF, 13'h000, 2'd0, T_REF,  "R3 R4 refresh 1");
        push_step(P_REF, 13'h000, 2'd0, T_REF,  "R3 R4 refresh 2");
        push_step(P_LMR, 13'h032, 2'd0, T_LOAD, "R3 R4 mode load final");
    endtask

    task automatic run_cycles(int n);
        exp_t e;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
            end else begin
                e.vec = mk(1'b1, P_NOP, 13'h0, 2'd0, 1'b1);
                e.tag = "R6 done hold";
            end
            check(e.vec, e.tag);
            checks++;
            if (cke !== 1'b1) begin
                errors++;
                $display("FAIL R7: cke got %b expected 1", cke);
            end
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(mk(1'b0, P_DES, 13'h0, 2'd0, 1'b0), "R1 reset state");

        build_model();
        rst = 1'b0;
        run_cycles(exp_q.size() + 12);

        // mid-sequence reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(mk(1'b0, P_DES, 13'h0, 2'd0, 1'b0), "R1 R8 reset after done");
        build_model();
        rst = 1'b0;
        run_cycles(10);
        rst = 1'b1;
        @(negedge clk);
        check(mk(1'b0, P_DES, 13'h0, 2'd0, 1'b0), "R8 reset mid sequence");
        @(negedge clk);
        check(mk(1'b0, P_DES, 13'h0, 2'd0, 1'b0), "R1 R8 held in reset");
        build_model();
        rst = 1'b0;
        run_cycles(exp_q.size() + 6);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule